// File: doc/BRIEF.md
# Nibble-Serial Instruction Receiver

This block collects one instruction word from an external host that sends it four bits at a time. The host supplies its own serial clock and a write strobe on a two-bit control input. The block brings the data, clock and strobe into the system clock domain through a short synchroniser chain. It looks for rising edges of the synchronised serial clock and captures one nibble on each edge that occurs while the strobe is high. After five such nibbles the block holds a 20-bit word made of an opcode and four operands, and it offers that word to a downstream decode stage with a valid/ready handshake.

A small state machine controls the block. It has two states. In `ST_FILL` the block counts captured nibbles and shifts each one into the word register. In `ST_HOLD` a complete word is waiting, and every host edge is ignored. The transition `FILL_TO_HOLD` happens when the fifth nibble is captured. The transition `HOLD_TO_FILL` happens on the clock edge where `valid_o` and `ready_i` are both high. Because the block takes no new data while a word is pending, backpressure from the decoder holds off the host without any word being lost.

Top module: `nibble_word_rx`

## Requirements
- R1: An active-low synchronous reset clears `valid_o`, `word_o` and the nibble count. A partly received word is discarded, and the next nibble after reset is treated as the first one of a new word.
- R2: `ctl_in[0]` is the host serial clock and `ctl_in[1]` is the write strobe. A nibble is captured only on a rising edge of the synchronised serial clock that occurs while the synchronised strobe is 1. Edges that occur while the strobe is 0 capture nothing.
- R3: The first captured nibble (the opcode) ends up in `word_o[19:16]`. The following nibbles ende up in order: a0 in `[15:12]`, a1 in `[11:8]`, b0 in `[7:4]` and b1 in `[3:0]`.
- R4: `valid_o` goes high after the fifth captured nibble and never after fewer than five.
- R5: While `valid_o` is 1 and `ready_i` is 0, `valid_o` stays at 1 and `word_o` does not change.
- R6: Strobed serial clock edges that arrive while a word is pending are ignored. They do not change the pending word, and they do not count toward the next word.
- R7: A handoff occurs on an edge where `valid_o` and `ready_i` are both 1. On the cycle after that edge `valid_o` is 0, and the next word is assembled starting from its first nibble.
- R8: A serial clock held high for many system cycles causes exactly one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_in | input | 4 | Nibble from the host |
| ctl_in | input | 2 | Bit 0: host serial clock. Bit 1: write strobe |
| ready_i | input | 1 | Decode stage can take the word |
| valid_o | output | 1 | A complete word is pending |
| word_o | output | 20 | Assembled word: opcode, a0, a1, b0, b1 from the top bits down |

## Verification
The bench sends serial clock pulses with the strobe low in the middle of a word. A design that ignored the strobe would shift in garbage and return a misaligned word. It stalls the decoder and keeps sending strobed nibbles. A design that kept filling during a pending word would change `word_o`, or it would return the next word short by the extra nibbles. It also resets the block in the middle of a word and checks that `valid_o` stays low after four nibbles. Either bug, a counter that survives reset or an off-by-one count, would show up as an early or mis-shifted word.

// File: rtl/nrx_pkg.sv
package nrx_pkg;
    localparam int NRX_NIB_W   = 4;
    localparam int NRX_NIBBLES = 5;
    localparam int NRX_SYNC    = 2;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_HOLD = 1'b1
    } nrx_state_e;
endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/nrx_edge.sv
module nrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/nrx_shift.sv
module nrx_shift #(
    parameter int NIB_W   = 4,
    parameter int NIBBLES = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [NIB_W-1:0]         nib_i,
    output logic [NIB_W*NIBBLES-1:0] word_o
);
    localparam int WORD_W = NIB_W * NIBBLES;

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (load_i) word_q <= {word_q[WORD_W-NIB_W-1:0], nib_i};
    end

    assign word_o = word_q;
endmodule

// File: rtl/nibble_word_rx.sv
module nibble_word_rx
    import nrx_pkg::*;
#(
    parameter int NIB_W       = NRX_NIB_W,
    parameter int NIBBLES     = NRX_NIBBLES,
    parameter int SYNC_STAGES = NRX_SYNC,
    parameter int WORD_W      = NIB_W * NIBBLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic [1:0]        ctl_in,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W  = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
    localparam int SYNC_W = NIB_W + 2;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NIBBLES - 1);

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] syn_bus;
    logic [NIB_W-1:0]  s_nib;
    logic              s_sclk;
    logic              s_stb;
    logic              sclk_rise;
    logic              cap_fire;

    nrx_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign raw_bus = {nib_in, ctl_in[1], ctl_in[0]};

    nrx_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_bus),
        .q_o   (syn_bus)
    );

    assign s_sclk = syn_bus[0];
    assign s_stb  = syn_bus[1];
    assign s_nib  = syn_bus[SYNC_W-1:2];

    nrx_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (s_sclk),
        .rise_o (sclk_rise)
    );

    assign cap_fire = sclk_rise & s_stb & (state_q == ST_FILL);

    nrx_shift #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cap_fire),
        .nib_i  (s_nib),
        .word_o (word_o)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (cap_fire) begin
                    if (cnt_q == LAST_CNT) begin
                        state_d = ST_HOLD;   // FILL_TO_HOLD
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (ready_i) begin
                    state_d = ST_FILL;       // HOLD_TO_FILL
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_FILL;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_HOLD: valid_o = 1'b1;
            default: valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/nrx_checker.sv
module nrx_checker #(
    parameter int WORD_W  = 20,
    parameter int CNT_W   = 3,
    parameter int NIBBLES = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready_i,
    input logic              valid_o,
    input logic [WORD_W-1:0] word_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              cap_fire
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && word_o == '0 && cnt_q == '0)); // R1

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NIBBLES - 1)); // R4

    AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(cap_fire)); // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(word_o))); // R5

    AST_PENDING_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !cap_fire); // R6

    AST_HANDOFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> (!valid_o && cnt_q == '0)); // R7
endmodule

bind nibble_word_rx nrx_checker #(
    .WORD_W  (WORD_W),
    .CNT_W   (CNT_W),
    .NIBBLES (NIBBLES)
) u_nrx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready_i  (ready_i),
    .valid_o  (valid_o),
    .word_o   (word_o),
    .cnt_q    (cnt_q),
    .cap_fire (cap_fire)
);

// File: tb/nibble_word_rx_bench.sv
module nibble_word_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  nib_in = '0;
    logic [1:0]  ctl_in = '0;
    logic        ready_i = 1'b1;
    logic        valid_o;
    logic [19:0] word_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [19:0] exp_q[$];

    always #2.5 clk = ~clk;

    nibble_word_rx u_nibble_word_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_in  (nib_in),
        .ctl_in  (ctl_in),
        .ready_i (ready_i),
        .valid_o (valid_o),
        .word_o  (word_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // one serial clock pulse, high phase held several cycles (R8)
    task automatic send_nib(input logic [3:0] n, input bit stb);
        @(posedge clk); #1;
        nib_in = n; ctl_in = {stb, 1'b0};
        wait_cyc(3); #1;
        ctl_in[0] = 1'b1;
        wait_cyc(6); #1;
        ctl_in[0] = 1'b0;
        wait_cyc(3); #1;
        ctl_in[1] = 1'b0;
    endtask

    task automatic send_word(input logic [19:0] w, input bit noise);
        exp_q.push_back(w);
        for (int k = 4; k >= 0; k--) begin
            send_nib(w[k*4 +: 4], 1'b1);
            if (noise) send_nib(4'hF - w[k*4 +: 4], 1'b0); // R2 unstrobed edge
        end
    endtask

    task automatic wait_valid;
        for (int i = 0; i < 100 && !valid_o; i++) @(posedge clk);
    endtask

    task automatic drain;
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
        chk(exp_q.size() == 0, "R7 word delivered", 20'(exp_q.size()), 20'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid_o && ready_i) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected word", word_o, 20'h0);
            end else begin
                logic [19:0] e;
                e = exp_q.pop_front();
                chk(word_o == e, "R3 word layout", word_o, e);
            end
        end
    end

    initial begin
        wait_cyc(3);
        @(negedge clk);
        chk(valid_o == 1'b0, "R1 reset valid", 20'(valid_o), 20'd0);
        chk(word_o == '0, "R1 reset word", word_o, 20'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R3: basic word, nibble order
        send_word(20'h1_2345, 1'b0);
        drain();
        // R2: unstrobed edges between nibbles
        send_word(20'hA_5C3E, 1'b1);
        drain();

        // R4: four nibbles give no valid
        for (int k = 4; k >= 1; k--) send_nib(4'h7 - 4'(k), 1'b1);
        wait_cyc(8); @(negedge clk);
        chk(valid_o == 1'b0, "R4 no valid after four", 20'(valid_o), 20'd0);
        // R1: reset mid-word discards partial
        @(posedge clk); #1 rst_n = 1'b0;
        wait_cyc(2); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 1'b0 && word_o == '0, "R1 mid-word reset", word_o, 20'd0);
        send_word(20'h9_0F18, 1'b0);
        drain();

        // R5/R6: stall and extra strobed nibbles
        @(posedge clk); #1 ready_i = 1'b0;
        send_word(20'hC_B7D2, 1'b0);
        wait_valid();
        @(negedge clk);
        chk(valid_o == 1'b1, "R5 valid while stalled", 20'(valid_o), 20'd1);
        chk(word_o == 20'hC_B7D2, "R5 word while stalled", word_o, 20'hC_B7D2);
        send_nib(4'h3, 1'b1);
        send_nib(4'h4, 1'b1);
        send_nib(4'h5, 1'b1);
        wait_cyc(6); @(negedge clk);
        chk(word_o == 20'hC_B7D2, "R6 pending word kept", word_o, 20'hC_B7D2);
        chk(valid_o == 1'b1, "R5 valid kept", 20'(valid_o), 20'd1);
        @(posedge clk); #1 ready_i = 1'b1;
        drain();
        @(negedge clk);
        chk(valid_o == 1'b0, "R7 valid drops after take", 20'(valid_o), 20'd0);

        // R7/R6: next word starts fresh
        send_word(20'h0_FEDC, 1'b0);
        drain();
        send_word(20'hF_0001, 1'b1);
        drain();

        wait_cyc(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule